// File: doc/BRIEF.md
# Five-Bit Teleprinter Frame Receiver

This block turns the sliced output of a tone demodulator into five-bit teleprinter characters. It receives one binary sample per clock on which the sample-enable input is high. Each bit spans many samples, and the number of samples per bit is set by a fixed-point input, so rates that give a non-integer count per bit are handled without drift inside a character.

The receiver waits on an idle mark line for a falling edge. It steps half a bit period to the middle of the start bit and confirms a space there, then takes a decision every full period after that. Each decision is a three-sample majority. The five data bits arrive least significant first. The decision at the stop position must read mark. The stop interval is used only as a gate before the receiver hunts again, and mark may idle for any length. Two reserved codes switch a letters/figures mode register. Every other character is handed out with a one-cycle strobe, a framing-error flag and the current mode.

Top module: `tty_frame_rx`

## Requirements
- R1: After reset `char_valid` is 0, `char_data` is 0, `frame_err` is 0 and `figs_mode` is 0 (letters).
- R2: A frame is a space (0) start bit, five data bits with the first received bit placed in `char_data[0]`, and a mark (1) stop bit. A good frame raises `char_valid` for exactly one clock with the five bits on `char_data`.
- R3: Counting the first space sample after a mark sample as sample 0, decision k (k = 0 for start, 1..5 for data, 6 for stop) is taken on sample floor(P/2 + k·P), where P is the samples per bit. `char_valid` goes high in the clock after the enabled edge of sample 6·P + P/2. A sender rate off by up to ±4% still decodes correctly at P = 16.
- R4: `bit_period` is unsigned 16.8 fixed point, so 4224 means 16.5 samples per bit. The fractional part is carried from bit to bit and is never cleared, so the decision points follow R3 exactly. The integer part must be at least 4.
- R5: Each decision is the majority of the current sample and the two samples before it, so a single flipped sample in that window does not change the decoded bit.
- R6: If the start-bit decision reads mark, the candidate is dropped with no output and the receiver hunts again.
- R7: If the stop decision reads space, the character is output with `frame_err` = 1. No new start is taken until the line has returned to mark and then fallen again.
- R8: Code 5'b11011 sets `figs_mode` to 1 and code 5'b11111 clears it to 0. Neither code raises `char_valid`. Every other good character is output with the current `figs_mode`, and a character with a framing error leaves the mode unchanged.
- R9: When `invert` is 1 the input sample is complemented before any other processing.
- R10: Frames that follow each other with a 1.5-bit stop interval and no extra idle are all decoded.
- R11: `char_data`, `frame_err` and `figs_mode` change only on a clock where `smp_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_en | input | 1 | Marks a clock that carries a new line sample |
| smp_in | input | 1 | Sliced demodulator sample, 1 = mark before inversion |
| invert | input | 1 | Complements the line sense when 1 |
| bit_period | input | 24 | Samples per bit, unsigned 16.8 fixed point |
| char_valid | output | 1 | One-clock strobe for a delivered character |
| char_data | output | 5 | Received character, first bit in bit 0 |
| frame_err | output | 1 | Stop position read space for this character |
| figs_mode | output | 1 | Shift mode, 1 = figures, 0 = letters |

## Verification
The assertions check on every cycle that the strobe lasts a single clock and follows an enabled sample, and that the character, error flag and mode move only on enabled samples. They also check that a mode change never comes with a strobe, that the error flag changes only together with a strobe, and that the bit clock is silent while hunting. The sample positions of decisions, fractional period carry, rate tolerance, vote immunity, glitch rejection, framing-error recovery, inversion and back-to-back framing depend on whole waveforms. Only the bench's directed scenarios can show them, by comparing decoded characters and the strobe's sample index with values computed from the requirements.

// File: rtl/tty_rx_pkg.sv
// Shared constants and types for the teleprinter frame receiver.
// Assumes five-bit codes; the shift codes are fixed by the line code.
package tty_rx_pkg;
    localparam int DATA_W = 5;
    localparam logic [DATA_W-1:0] CODE_LTRS = 5'b11111;
    localparam logic [DATA_W-1:0] CODE_FIGS = 5'b11011;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/tty_rx_sampler.sv
// Line front end: applies polarity, keeps the last two samples, and
// produces a three-sample majority and a mark-to-space edge flag.
// Assumes one sample per clock with smp_en high; outputs are combinational
// on the current sample so a decision can be taken in the same clock.
module tty_rx_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic smp_in,
    input  logic invert,
    output logic line_vote,
    output logic line_fall
);
    logic       line_now;
    logic [1:0] hist;

    assign line_now = smp_in ^ invert;

    // Sample history, initialised to the idle mark level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= 2'b11;
        else if (smp_en)
            hist <= {hist[0], line_now};
    end

    // Majority of the two stored samples and the current one.
    always_comb begin
        line_vote = (hist[1] & hist[0]) | (hist[1] & line_now) | (hist[0] & line_now);
    end

    // Falling edge: previous sample mark, current sample space.
    always_comb begin
        line_fall = smp_en & hist[0] & ~line_now;
    end
endmodule

// File: rtl/tty_rx_bitclk.sv
// Fractional bit-period timer. On load it starts half a period ahead;
// afterwards it counts whole samples down and adds the full period back
// when it expires, keeping the fraction. Assumes period >= 2.0.
module tty_rx_bitclk #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_en,
    input  logic                      load,
    input  logic                      run,
    input  logic [INT_W+FRAC_W-1:0]   period,
    output logic                      tick
);
    localparam int PER_W = INT_W + FRAC_W;
    localparam logic [PER_W-1:0] ONE = PER_W'(1) << FRAC_W;

    logic [PER_W-1:0] acc;
    logic [PER_W-1:0] half;

    assign half = period >> 1;

    // Decision point: running and less than one sample remains.
    always_comb begin
        tick = smp_en & run & (acc < ONE);
    end

    // Phase accumulator: load half period, step one sample, reload with carry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (smp_en) begin
            if (load)
                acc <= (half >= ONE) ? (half - ONE) : '0;
            else if (run)
                acc <= (acc < ONE) ? (acc + period - ONE) : (acc - ONE);
        end
    end
endmodule

// File: rtl/tty_rx_ctrl.sv
// Frame sequencer: confirms the start bit, shifts in the data bits first
// bit lowest, judges the stop position, tracks the shift mode and drives
// the character outputs. Assumes decisions arrive as single-clock ticks.
module tty_rx_ctrl
    import tty_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_fall,
    input  logic              line_vote,
    input  logic              tick,
    output logic              load,
    output logic              run,
    output logic              hunting,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data,
    output logic              frame_err,
    output logic              figs_mode
);
    localparam int IDX_W = $clog2(DATA_W);

    rx_state_t         state;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;

    // Timer control derived from the current state.
    always_comb begin
        hunting = (state == ST_HUNT);
        load    = hunting & line_fall;
        run     = ~hunting;
    end

    // Frame state machine and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HUNT;
            bit_idx    <= '0;
            shreg      <= '0;
            char_valid <= 1'b0;
            char_data  <= '0;
            frame_err  <= 1'b0;
            figs_mode  <= 1'b0;
        end else begin
            char_valid <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (line_fall)
                        state <= ST_START;
                end
                ST_START: begin
                    if (tick) begin
                        if (line_vote)
                            state <= ST_HUNT;
                        else begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        shreg <= {line_vote, shreg[DATA_W-1:1]};
                        if (bit_idx == IDX_W'(DATA_W - 1))
                            state <= ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        state <= ST_HUNT;
                        if (!line_vote) begin
                            char_valid <= 1'b1;
                            char_data  <= shreg;
                            frame_err  <= 1'b1;
                        end else if (shreg == CODE_LTRS)
                            figs_mode <= 1'b0;
                        else if (shreg == CODE_FIGS)
                            figs_mode <= 1'b1;
                        else begin
                            char_valid <= 1'b1;
                            char_data  <= shreg;
                            frame_err  <= 1'b0;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/tty_frame_rx.sv
// Top of the five-bit teleprinter frame receiver: line front end,
// fractional bit timer and frame sequencer. Assumes bit_period is
// 16.8 fixed point with an integer part of at least 4.
module tty_frame_rx #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    smp_in,
    input  logic                    invert,
    input  logic [INT_W+FRAC_W-1:0] bit_period,
    output logic                    char_valid,
    output logic [4:0]              char_data,
    output logic                    frame_err,
    output logic                    figs_mode
);
    logic line_vote;
    logic line_fall;
    logic bit_tick;
    logic tmr_load;
    logic tmr_run;
    logic hunting;

    tty_rx_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (smp_en),
        .smp_in    (smp_in),
        .invert    (invert),
        .line_vote (line_vote),
        .line_fall (line_fall)
    );

    tty_rx_bitclk #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .load   (tmr_load),
        .run    (tmr_run),
        .period (bit_period),
        .tick   (bit_tick)
    );

    tty_rx_ctrl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_fall  (line_fall),
        .line_vote  (line_vote),
        .tick       (bit_tick),
        .load       (tmr_load),
        .run        (tmr_run),
        .hunting    (hunting),
        .char_valid (char_valid),
        .char_data  (char_data),
        .frame_err  (frame_err),
        .figs_mode  (figs_mode)
    );
endmodule

// File: rtl/tty_frame_rx_chk.sv
// Property checker for tty_frame_rx, attached by bind below.
module tty_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_en,
    input logic       char_valid,
    input logic [4:0] char_data,
    input logic       frame_err,
    input logic       figs_mode,
    input logic       bit_tick,
    input logic       hunting
);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R2
    valid_after_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(smp_en));

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> ($stable(char_data) && $stable(frame_err) && $stable(figs_mode)));

    // R8
    shift_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(figs_mode) |-> !char_valid);

    // R7
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_err) |-> char_valid);

    // R6
    no_tick_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |-> !bit_tick);
endmodule

bind tty_frame_rx tty_frame_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .char_valid (char_valid),
    .char_data  (char_data),
    .frame_err  (frame_err),
    .figs_mode  (figs_mode),
    .bit_tick   (bit_tick),
    .hunting    (hunting)
);

// File: tb/tb_tty_frame_rx.sv
module tb_tty_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic        smp_in = 1'b1;
    logic        invert = 1'b0;
    logic [23:0] bit_period = 24'd4096;
    logic        char_valid;
    logic [4:0]  char_data;
    logic        frame_err;
    logic        figs_mode;

    int n_chk = 0;
    int n_fail = 0;
    int smp_idx = 0;
    int got_cnt = 0;
    int got_idx = 0;
    int frame_idx = 0;
    logic [4:0] got_data = '0;
    logic       got_err = 1'b0;
    logic       got_figs = 1'b0;
    logic [4:0] got_log [8];
    logic       tx_inv = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    tty_frame_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_en     (smp_en),
        .smp_in     (smp_in),
        .invert     (invert),
        .bit_period (bit_period),
        .char_valid (char_valid),
        .char_data  (char_data),
        .frame_err  (frame_err),
        .figs_mode  (figs_mode)
    );

    // Capture strobes between clock edges.
    always @(negedge clk) begin
        if (rst_n && char_valid) begin
            got_log[got_cnt % 8] = char_data;
            got_cnt  = got_cnt + 1;
            got_data = char_data;
            got_err  = frame_err;
            got_figs = figs_mode;
            got_idx  = smp_idx;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_sample(input logic b);
        @(negedge clk);
        smp_en  = 1'b1;
        smp_in  = b ^ tx_inv;
        smp_idx = smp_idx + 1;
        @(negedge clk);
        smp_en = 1'b0;
    endtask

    task automatic idle(input int n, input logic lvl);
        for (int i = 0; i < n; i++) send_sample(lvl);
    endtask

    // One frame at spb samples per bit; flip_bit >= 0 flips its middle sample.
    task automatic send_frame(input logic [4:0] d, input real spb, input real stop_bits,
                              input logic stop_lvl, input int flip_bit);
        int prev_end = 0;
        frame_idx = smp_idx + 1;
        for (int i = 0; i < 7; i++) begin
            int e;
            int n;
            logic lvl;
            if (i < 6) e = $rtoi((i + 1) * spb + 0.5);
            else       e = $rtoi((6.0 + stop_bits) * spb + 0.5);
            n = e - prev_end;
            prev_end = e;
            lvl = (i == 0) ? 1'b0 : (i < 6) ? d[i-1] : stop_lvl;
            for (int s = 0; s < n; s++)
                send_sample((i == flip_bit && s == n / 2) ? ~lvl : lvl);
        end
    endtask

    task automatic expect_char(input string req, input int cnt0, input logic [4:0] d,
                               input logic err, input logic figs);
        check(got_cnt == cnt0 + 1, req, got_cnt - cnt0, 1);
        check(got_data == d, req, got_data, d);
        check(got_err == err, req, got_err, err);
        check(got_figs == figs, req, got_figs, figs);
    endtask

    task automatic t_reset;
        check(char_valid == 1'b0, "R1", char_valid, 0);
        check(char_data == 5'd0, "R1", char_data, 0);
        check(frame_err == 1'b0, "R1", frame_err, 0);
        check(figs_mode == 1'b0, "R1", figs_mode, 0);
    endtask

    task automatic t_basic;
        int c;
        bit_period = 24'd4096;
        idle(40, 1'b1);
        c = got_cnt;
        send_frame(5'h01, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R2", c, 5'h01, 1'b0, 1'b0);
        // R3: strobe after sample 6*16+8 counted from the start sample
        check(got_idx - frame_idx == 104, "R3", got_idx - frame_idx, 104);
        c = got_cnt;
        send_frame(5'h10, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R2", c, 5'h10, 1'b0, 1'b0);
        c = got_cnt;
        send_frame(5'h0A, 16.0, 3.0, 1'b1, -1);
        idle(30, 1'b1);
        expect_char("R2", c, 5'h0A, 1'b0, 1'b0);
    endtask

    task automatic t_frac;
        int c;
        bit_period = 24'd4224;
        idle(20, 1'b1);
        c = got_cnt;
        send_frame(5'h13, 16.5, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R4", c, 5'h13, 1'b0, 1'b0);
        // R4: floor(8.25 + 6*16.5) = 107
        check(got_idx - frame_idx == 107, "R4", got_idx - frame_idx, 107);
        bit_period = 24'd4096;
        idle(10, 1'b1);
    endtask

    task automatic t_tol;
        int c;
        c = got_cnt;
        send_frame(5'h15, 16.6, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R3", c, 5'h15, 1'b0, 1'b0);
        c = got_cnt;
        send_frame(5'h0E, 15.4, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R3", c, 5'h0E, 1'b0, 1'b0);
    endtask

    task automatic t_vote;
        int c;
        c = got_cnt;
        send_frame(5'h00, 16.0, 1.5, 1'b1, 3);
        idle(10, 1'b1);
        expect_char("R5", c, 5'h00, 1'b0, 1'b0);
        c = got_cnt;
        send_frame(5'h1D, 16.0, 1.5, 1'b1, 2);
        idle(10, 1'b1);
        expect_char("R5", c, 5'h1D, 1'b0, 1'b0);
    endtask

    task automatic t_glitch;
        int c;
        idle(20, 1'b1);
        c = got_cnt;
        idle(3, 1'b0);
        idle(40, 1'b1);
        check(got_cnt == c, "R6", got_cnt - c, 0);
        send_frame(5'h06, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R6", c, 5'h06, 1'b0, 1'b0);
    endtask

    task automatic t_ferr;
        int c;
        c = got_cnt;
        send_frame(5'h09, 16.0, 1.5, 1'b0, -1);
        idle(80, 1'b0);
        expect_char("R7", c, 5'h09, 1'b1, 1'b0);
        idle(30, 1'b1);
        c = got_cnt;
        send_frame(5'h0C, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R7", c, 5'h0C, 1'b0, 1'b0);
    endtask

    task automatic t_shift;
        int c;
        c = got_cnt;
        send_frame(5'b11011, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        check(got_cnt == c, "R8", got_cnt - c, 0);
        check(figs_mode == 1'b1, "R8", figs_mode, 1);
        send_frame(5'h05, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R8", c, 5'h05, 1'b0, 1'b1);
        c = got_cnt;
        send_frame(5'b11111, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        check(got_cnt == c, "R8", got_cnt - c, 0);
        check(figs_mode == 1'b0, "R8", figs_mode, 0);
        send_frame(5'h05, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R8", c, 5'h05, 1'b0, 1'b0);
    endtask

    task automatic t_inv;
        int c;
        @(negedge clk);
        tx_inv = 1'b1;
        invert = 1'b1;
        smp_in = 1'b0;
        idle(20, 1'b1);
        c = got_cnt;
        send_frame(5'h12, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        expect_char("R9", c, 5'h12, 1'b0, 1'b0);
        @(negedge clk);
        tx_inv = 1'b0;
        invert = 1'b0;
        smp_in = 1'b1;
        idle(10, 1'b1);
    endtask

    task automatic t_b2b;
        int c;
        c = got_cnt;
        send_frame(5'h03, 16.0, 1.5, 1'b1, -1);
        send_frame(5'h18, 16.0, 1.5, 1'b1, -1);
        send_frame(5'h07, 16.0, 1.5, 1'b1, -1);
        idle(10, 1'b1);
        check(got_cnt == c + 3, "R10", got_cnt - c, 3);
        check(got_log[c % 8] == 5'h03, "R10", got_log[c % 8], 5'h03);
        check(got_log[(c + 1) % 8] == 5'h18, "R10", got_log[(c + 1) % 8], 5'h18);
        check(got_log[(c + 2) % 8] == 5'h07, "R10", got_log[(c + 2) % 8], 5'h07);
    endtask

    task automatic t_hold;
        logic [4:0] d0;
        logic       f0;
        int         c;
        d0 = char_data;
        f0 = figs_mode;
        c  = got_cnt;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            smp_in = ~smp_in;
        end
        @(negedge clk);
        smp_in = 1'b1;
        check(char_data == d0, "R11", char_data, d0);
        check(figs_mode == f0, "R11", figs_mode, f0);
        check(got_cnt == c, "R11", got_cnt - c, 0);
        idle(10, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_frac;
        t_tol;
        t_vote;
        t_glitch;
        t_ferr;
        t_shift;
        t_inv;
        t_b2b;
        t_hold;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule